// File: doc/BRIEF.md
# Watchdog Timer with Address-Mapped Clear

This block is the computer-operating-properly watchdog of a small 8-bit microcontroller. It has a free-running prescaler that feeds a timeout counter. When the combined count reaches the selected limit, the block issues a one-cycle reset request. It then restarts its own count from zero. A configuration bit chooses between a long and a short timeout. The watchdog never raises an interrupt.

The block snoops the CPU bus. A write of any data to the top-of-memory address restarts the full timeout period. A read of that same address does not return a register value. Instead, the low byte of the reset vector, supplied by program memory, is passed through onto the read data.

Mode inputs change how the timer runs:
- Wait mode leaves it counting.
- Stop mode zeroes the prescaler and freezes the counter.
- Monitor-mode and break conditions that involve the high test voltage force it off.
- Entry into monitor mode because of a blank reset vector forces it off until the next power-on reset.

The block also flags an illegal-opcode reset when STOP is executed while configuration forbids it.

Top module: `cop_watchdog`

## Requirements
- R1: A write (`bus_wr`=1) to address 0xFFFF restarts the timeout. The data value plays no part. `rst_req` is then high in the cycle that follows the LIMIT-th rising edge after the edge that sampled the write, where LIMIT is the limit for the current rate.
- R2: A write to any other address has no effect on the timing of `rst_req`. So does a read of 0xFFFF.
- R3: While `bus_rd`=1 and `bus_addr`=0xFFFF, `bus_rdata` equals `rvec_lo` in the same cycle (combinational). In every other case, `bus_rdata` is 0x00.
- R4: `rst_req` is high for exactly one cycle. The count then restarts from zero, so without clears the pulses repeat every LIMIT cycles.
- R5: With `rate_sel`=0, LIMIT is 2^(PRE_W+CNT_W) − 2^TRIM_W, which is 262128 by default. With `rate_sel`=1, LIMIT is 2^(PRE_W+CNT_W−SHORT_SHIFT) − 2^TRIM_W, which is 8176 by default.
- R6: `wait_mode` has no effect on counting or on the timing of `rst_req`.
- R7: While `stop_mode`=1, the prescaler is held at zero, the counter keeps its value, and `rst_req` stays low. After stop ends, the pulse comes LIMIT − C·2^PRE_W edges later, where C is the held counter value.
- R8: While `mon_vtst_entry`=1 and either `vtst_irq` or `vtst_rst` is 1, the watchdog is off. During that time `rst_req` stays low and the count is cleared. The first enabled edge starts a full period.
- R9: A one-cycle pulse on `mon_blank_entry` turns the watchdog off and keeps it off. The condition survives `rst_n` and is cleared only by `por_n`=0.
- R10: While `brk_active`=1 and `vtst_rst`=1, the watchdog is off, as in R8. `brk_active` alone does not stop it.
- R11: A cycle with `stop_exec`=1 and `cfg_stop_dis`=1 makes `illop_req` high for exactly the next cycle. With `cfg_stop_dis`=0, `illop_req` stays low.
- R12: `rst_n`=0 or `por_n`=0, sampled at a rising edge, clears the count and both request outputs. A full period follows the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog input clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| por_n | input | 1 | Synchronous active-low power-on reset |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | CPU write strobe |
| bus_rd | input | 1 | CPU read strobe |
| rvec_lo | input | 8 | Low byte of the reset vector from program memory |
| bus_rdata | output | 8 | Read data driven for the clear address |
| rate_sel | input | 1 | Timeout select: 0 long, 1 short |
| cfg_stop_dis | input | 1 | Configuration: STOP instruction forbidden |
| wait_mode | input | 1 | CPU in wait mode |
| stop_mode | input | 1 | CPU in stop mode (watchdog clock removed) |
| stop_exec | input | 1 | One-cycle pulse: CPU executes STOP |
| mon_vtst_entry | input | 1 | Monitor mode was entered through the test voltage on IRQ |
| mon_blank_entry | input | 1 | One-cycle pulse: monitor entry due to a blank reset vector |
| vtst_irq | input | 1 | Test voltage present on IRQ |
| vtst_rst | input | 1 | Test voltage present on RST |
| brk_active | input | 1 | Break interrupt in progress |
| rst_req | output | 1 | One-cycle watchdog reset request |
| illop_req | output | 1 | One-cycle illegal-opcode reset request |

## Verification
The count is one register chain: one increment per edge, and a registered pulse that appears one cycle after the count reaches LIMIT − 1. So `rst_req` is due in the cycle after the LIMIT-th edge that follows a clear, a reset release or the end of a disable. It is due LIMIT − C·2^PRE_W edges after stop ends.

`illop_req` is due one edge after the STOP cycle. `bus_rdata` is due in the same cycle as the read.

The bench changes inputs on falling edges and samples on falling edges. It counts the edges each task consumes and checks the pulse as low one cycle early, high on time, and low again one cycle later. The bench is built with a 6-bit prescaler so both rates fit in a short run.

// File: rtl/cop_pkg.sv
// cop_pkg: shared types and limit arithmetic for the watchdog.
// Assumes limits fit in 32-bit integer arithmetic (total width <= 30).
package cop_pkg;

    typedef enum logic {
        RATE_LONG  = 1'b0,
        RATE_SHORT = 1'b1
    } cop_rate_e;

    // Number of input clocks from a clear to the reset request.
    function automatic int cop_limit(input int tot_w, input int shift, input int trim_w);
        return (1 << (tot_w - shift)) - (1 << trim_w);
    endfunction

endpackage

// File: rtl/cop_bus_decode.sv
// cop_bus_decode: snoops the CPU bus for the clear address.
// A write there (data ignored) yields a one-cycle clear; a read there
// passes the reset-vector low byte through. Assumes strobes are
// valid for one clock per access.
module cop_bus_decode #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] rvec_lo,
    output logic              clr,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [ADDR_W-1:0] CLR_ADDR = '1;

    logic hit;

    // Address match against the top of memory.
    always_comb begin
        hit = (bus_addr == CLR_ADDR);
    end

    // Clear strobe and read pass-through.
    always_comb begin
        clr       = bus_wr && hit;
        bus_rdata = (bus_rd && hit) ? rvec_lo : '0;
    end

    always_comb begin
        a_r3_rdata_zero_off_addr: assert (hit || (bus_rdata == '0));
    end

endmodule

// File: rtl/cop_prescaler.sv
// cop_prescaler: free-running divide stage of the watchdog.
// Zeroed by reset, by clear and by stop mode; emits a carry on wrap.
// Assumes zero_i covers clears, disables and timeouts.
module cop_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_i,
    input  logic             stop_i,
    output logic [PRE_W-1:0] pre_q,
    output logic             carry_o
);
    localparam logic [PRE_W-1:0] PRE_MAX = '1;

    // Prescaler count register.
    always_ff @(posedge clk) begin
        if (!rst_n || zero_i || stop_i) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Carry into the main counter on wrap.
    always_comb begin
        carry_o = (pre_q == PRE_MAX) && !zero_i && !stop_i;
    end

    a_r7_stop_prescaler_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (pre_q == '0));

endmodule

// File: rtl/cop_counter.sv
// cop_counter: main timeout counter, advanced by prescaler carries.
// Holds its value when no carry arrives (stop mode).
module cop_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zero_i,
    input  logic             carry_i,
    input  logic             hold_i,
    output logic [CNT_W-1:0] cnt_q
);
    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n || zero_i) begin
            cnt_q <= '0;
        end else if (carry_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r7_stop_counter_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !zero_i) |=> $stable(cnt_q));

endmodule

// File: rtl/cop_ctrl.sv
// cop_ctrl: disable conditions, timeout compare and reset requests.
// The blank-vector disable is sticky and only power-on reset clears it.
// Assumes stop_exec and mon_blank_entry are single-cycle pulses.
module cop_ctrl
    import cop_pkg::*;
#(
    parameter int TOT_W       = 18,
    parameter int SHORT_SHIFT = 5,
    parameter int TRIM_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic [TOT_W-1:0] total,
    input  cop_rate_e        rate,
    input  logic             clr,
    input  logic             stop_mode,
    input  logic             stop_exec,
    input  logic             cfg_stop_dis,
    input  logic             mon_vtst_entry,
    input  logic             mon_blank_entry,
    input  logic             vtst_irq,
    input  logic             vtst_rst,
    input  logic             brk_active,
    output logic             disabled,
    output logic             timeout,
    output logic             rst_req,
    output logic             illop_req
);
    localparam int LONG_LIM  = cop_limit(TOT_W, 0, TRIM_W);
    localparam int SHORT_LIM = cop_limit(TOT_W, SHORT_SHIFT, TRIM_W);
    localparam logic [TOT_W-1:0] LONG_END  = TOT_W'(LONG_LIM - 1);
    localparam logic [TOT_W-1:0] SHORT_END = TOT_W'(SHORT_LIM - 1);

    logic             any_rst_n;
    logic             blank_q;
    logic             vtst_off;
    logic             brk_off;
    logic [TOT_W-1:0] end_val;

    // Combined reset.
    always_comb begin
        any_rst_n = rst_n && por_n;
    end

    // Sticky blank-vector monitor disable, cleared by power-on only.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            blank_q <= 1'b0;
        end else if (mon_blank_entry) begin
            blank_q <= 1'b1;
        end
    end

    // Disable sources.
    always_comb begin
        vtst_off = mon_vtst_entry && (vtst_irq || vtst_rst);
        brk_off  = brk_active && vtst_rst;
        disabled = vtst_off || brk_off || blank_q;
    end

    // Terminal value for the selected rate.
    always_comb begin
        end_val = (rate == RATE_SHORT) ? SHORT_END : LONG_END;
        timeout = (total == end_val) && !disabled && !stop_mode && !clr;
    end

    // Registered watchdog reset pulse.
    always_ff @(posedge clk) begin
        if (!any_rst_n) begin
            rst_req <= 1'b0;
        end else begin
            rst_req <= timeout;
        end
    end

    // Registered illegal-opcode pulse for a forbidden STOP.
    always_ff @(posedge clk) begin
        if (!any_rst_n) begin
            illop_req <= 1'b0;
        end else begin
            illop_req <= stop_exec && cfg_stop_dis;
        end
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!any_rst_n)
        rst_req |=> !rst_req);

    a_r8_off_no_request: assert property (@(posedge clk) disable iff (!any_rst_n)
        disabled |=> !rst_req);

    a_r11_illop_needs_cfg: assert property (@(posedge clk) disable iff (!any_rst_n)
        illop_req |-> $past(cfg_stop_dis));

    a_r9_blank_sticky: assert property (@(posedge clk) disable iff (!por_n)
        blank_q |=> blank_q);

endmodule

// File: rtl/cop_watchdog.sv
// cop_watchdog: top of the watchdog. It ties the bus decode, the
// prescaler, the counter and the control logic together. Assumes a
// single clock domain with synchronous active-low resets.
module cop_watchdog
    import cop_pkg::*;
#(
    parameter int PRE_W       = 12,
    parameter int CNT_W       = 6,
    parameter int SHORT_SHIFT = 5,
    parameter int TRIM_W      = 4,
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] rvec_lo,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rate_sel,
    input  logic              cfg_stop_dis,
    input  logic              wait_mode,
    input  logic              stop_mode,
    input  logic              stop_exec,
    input  logic              mon_vtst_entry,
    input  logic              mon_blank_entry,
    input  logic              vtst_irq,
    input  logic              vtst_rst,
    input  logic              brk_active,
    output logic              rst_req,
    output logic              illop_req
);
    localparam int TOT_W = PRE_W + CNT_W;

    logic             any_rst_n;
    logic             clr;
    logic             disabled;
    logic             timeout;
    logic             zero;
    logic             carry;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TOT_W-1:0] total;
    cop_rate_e        rate;

    // Reset merge, zero request and combined count view.
    always_comb begin
        any_rst_n = rst_n && por_n;
        zero      = clr || disabled || timeout;
        total     = {cnt_q, pre_q};
        rate      = cop_rate_e'(rate_sel);
    end

    cop_bus_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .rvec_lo   (rvec_lo),
        .clr       (clr),
        .bus_rdata (bus_rdata)
    );

    cop_prescaler #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (any_rst_n),
        .zero_i  (zero),
        .stop_i  (stop_mode),
        .pre_q   (pre_q),
        .carry_o (carry)
    );

    cop_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (any_rst_n),
        .zero_i  (zero),
        .carry_i (carry),
        .hold_i  (stop_mode),
        .cnt_q   (cnt_q)
    );

    cop_ctrl #(
        .TOT_W       (TOT_W),
        .SHORT_SHIFT (SHORT_SHIFT),
        .TRIM_W      (TRIM_W)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .por_n           (por_n),
        .total           (total),
        .rate            (rate),
        .clr             (clr),
        .stop_mode       (stop_mode),
        .stop_exec       (stop_exec),
        .cfg_stop_dis    (cfg_stop_dis),
        .mon_vtst_entry  (mon_vtst_entry),
        .mon_blank_entry (mon_blank_entry),
        .vtst_irq        (vtst_irq),
        .vtst_rst        (vtst_rst),
        .brk_active      (brk_active),
        .disabled        (disabled),
        .timeout         (timeout),
        .rst_req         (rst_req),
        .illop_req       (illop_req)
    );

    a_r6_wait_counts: assert property (@(posedge clk) disable iff (!any_rst_n)
        (wait_mode && !stop_mode && !zero) |=> (total == $past(total) + TOT_W'(1)));

    a_r1_clear_no_request: assert property (@(posedge clk) disable iff (!any_rst_n)
        clr |=> !rst_req);

endmodule

// File: tb/cop_watchdog_tb.sv
`timescale 1ns/1ps
module cop_watchdog_tb;
    localparam int PRE_W = 6;
    localparam int CNT_W = 6;
    localparam int SHIFT = 5;
    localparam int TRIM  = 4;
    localparam int LONG  = (1 << (PRE_W + CNT_W)) - (1 << TRIM);
    localparam int SHORT = (1 << (PRE_W + CNT_W - SHIFT)) - (1 << TRIM);

    logic clk = 1'b0;
    logic rst_n, por_n, bus_wr, bus_rd, rate_sel, cfg_stop_dis;
    logic wait_mode, stop_mode, stop_exec, mon_vtst_entry, mon_blank_entry;
    logic vtst_irq, vtst_rst, brk_active;
    logic [15:0] bus_addr;
    logic [7:0]  rvec_lo, bus_rdata;
    logic        rst_req, illop_req;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cop_watchdog #(
        .PRE_W (PRE_W), .CNT_W (CNT_W), .SHORT_SHIFT (SHIFT), .TRIM_W (TRIM)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .por_n (por_n), .bus_addr (bus_addr),
        .bus_wr (bus_wr), .bus_rd (bus_rd), .rvec_lo (rvec_lo), .bus_rdata (bus_rdata),
        .rate_sel (rate_sel), .cfg_stop_dis (cfg_stop_dis), .wait_mode (wait_mode),
        .stop_mode (stop_mode), .stop_exec (stop_exec), .mon_vtst_entry (mon_vtst_entry),
        .mon_blank_entry (mon_blank_entry), .vtst_irq (vtst_irq), .vtst_rst (vtst_rst),
        .brk_active (brk_active), .rst_req (rst_req), .illop_req (illop_req)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Pulse expected after n edges from the current falling edge.
    task automatic expect_pulse(input string tag, input int n);
        step(n - 1);
        check({tag, " early"}, {7'd0, rst_req}, 8'h00);
        step(1);
        check({tag, " due"}, {7'd0, rst_req}, 8'h01);
        step(1);
        check({tag, " width"}, {7'd0, rst_req}, 8'h00);
    endtask

    task automatic expect_quiet(input string tag, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (rst_req) seen++;
        end
        check(tag, 8'(seen), 8'h00);
    endtask

    task automatic bus_write(input logic [15:0] a);
        bus_addr = a; bus_wr = 1'b1;
        step(1);
        bus_wr = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic bus_read(input logic [15:0] a);
        bus_addr = a; bus_rd = 1'b1;
        step(1);
        bus_rd = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; por_n = 1'b0;
        step(2);
        check("R12 rst_req in reset", {7'd0, rst_req}, 8'h00);
        check("R12 illop in reset", {7'd0, illop_req}, 8'h00);
        rst_n = 1'b1; por_n = 1'b1;
        expect_pulse("R12 full period after power-on", SHORT);
    endtask

    task automatic t_restart;
        rate_sel = 1'b1;
        step(30);
        bus_write(16'hFFFF);
        expect_pulse("R1 short restart", SHORT);
        expect_pulse("R4 auto repeat", SHORT - 1);
        rate_sel = 1'b0;
        bus_write(16'hFFFF);
        expect_pulse("R5 long limit", LONG);
        rate_sel = 1'b1;
    endtask

    task automatic t_ignore;
        bus_write(16'hFFFF);
        step(20);
        bus_write(16'hFFFE);
        bus_read(16'hFFFF);
        expect_pulse("R2 other write and read ignored", SHORT - 22);
    endtask

    task automatic t_read;
        bus_rd = 1'b1; bus_addr = 16'hFFFF; rvec_lo = 8'h5A;
        #1 check("R3 vector pass", bus_rdata, 8'h5A);
        rvec_lo = 8'hA5;
        #1 check("R3 vector follows", bus_rdata, 8'hA5);
        bus_addr = 16'hFFFE;
        #1 check("R3 other address", bus_rdata, 8'h00);
        bus_rd = 1'b0; bus_addr = 16'hFFFF;
        #1 check("R3 no strobe", bus_rdata, 8'h00);
        bus_addr = 16'h0000;
        step(1);
    endtask

    task automatic t_wait;
        wait_mode = 1'b1;
        bus_write(16'hFFFF);
        expect_pulse("R6 wait keeps counting", SHORT);
        wait_mode = 1'b0;
    endtask

    task automatic t_stop;
        bus_write(16'hFFFF);
        step(70);
        stop_mode = 1'b1;
        expect_quiet("R7 quiet in stop", 200);
        stop_mode = 1'b0;
        expect_pulse("R7 resume after stop", SHORT - (1 << PRE_W));
    endtask

    task automatic t_mon_vtst;
        mon_vtst_entry = 1'b1; vtst_irq = 1'b1;
        expect_quiet("R8 off with vtst on irq", 300);
        vtst_irq = 1'b0; vtst_rst = 1'b1;
        expect_quiet("R8 off with vtst on rst", 300);
        vtst_rst = 1'b0;
        expect_pulse("R8 full period after release", SHORT);
        mon_vtst_entry = 1'b0;
    endtask

    task automatic t_brk;
        brk_active = 1'b1; vtst_rst = 1'b1;
        expect_quiet("R10 off in break with vtst", 300);
        vtst_rst = 1'b0;
        expect_pulse("R10 break alone counts", SHORT);
        brk_active = 1'b0;
    endtask

    task automatic t_blank;
        mon_blank_entry = 1'b1;
        step(1);
        mon_blank_entry = 1'b0;
        expect_quiet("R9 off after blank entry", 300);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        expect_quiet("R9 survives system reset", 300);
        por_n = 1'b0;
        step(1);
        por_n = 1'b1;
        expect_pulse("R9 power-on re-enables", SHORT);
    endtask

    task automatic t_sysreset;
        step(40);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        expect_pulse("R12 system reset restarts", SHORT);
    endtask

    task automatic t_illop;
        cfg_stop_dis = 1'b1; stop_exec = 1'b1;
        step(1);
        stop_exec = 1'b0;
        check("R11 illop due", {7'd0, illop_req}, 8'h01);
        step(1);
        check("R11 illop width", {7'd0, illop_req}, 8'h00);
        cfg_stop_dis = 1'b0; stop_exec = 1'b1;
        step(1);
        stop_exec = 1'b0;
        check("R11 allowed stop no illop", {7'd0, illop_req}, 8'h00);
        step(1);
        check("R11 allowed stop later", {7'd0, illop_req}, 8'h00);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; por_n = 1'b0; bus_addr = 16'h0000; bus_wr = 1'b0; bus_rd = 1'b0;
        rvec_lo = 8'h00; rate_sel = 1'b1; cfg_stop_dis = 1'b0; wait_mode = 1'b0;
        stop_mode = 1'b0; stop_exec = 1'b0; mon_vtst_entry = 1'b0; mon_blank_entry = 1'b0;
        vtst_irq = 1'b0; vtst_rst = 1'b0; brk_active = 1'b0;
        @(negedge clk);
        t_reset();
        t_read();
        t_restart();
        t_ignore();
        t_wait();
        t_stop();
        t_mon_vtst();
        t_brk();
        t_blank();
        t_sysreset();
        t_illop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule